// File: doc/BRIEF.md
# Command-Register Serial Interface Controller

This block is the serial slave that sits in front of a converter's register bank. A host reaches it over three wires: a serial clock, a data input and a data output. The chip-select line is tied active. Every access is indirect. The host first shifts in an 8-bit command byte. That byte names the target register, the direction and the active input channel. The controller then moves exactly one word of that register's width and falls back to waiting for the next command byte. If a host loses track of the framing, it can clock in a long run of ones to force the interface back to the command-wait state.

The serial pins are sampled in the block's system clock domain and their edges are detected there. The registers behind the interface are a stub bank: four 8-bit control registers, one zero-scale and one full-scale calibration word per channel, and a read-only conversion word taken from an input port. The command register itself can be read back. It reports the data-ready flag together with the fields of the command byte.

Top module: `cmdif_top`

## Requirements
- R1: After reset the interface waits for a command byte, `sdo` is low and `chan_sel` is 0.
- R2: Serial bits are taken on the rising `sclk` edge, MSB first. In a command byte, bit 7 must be 0 for the byte to be valid. Bits 6:4 select the register, bit 3 set means read and clear means write, and bits 2:0 give the channel. `chan_sel` takes the channel field of every valid command.
- R3: A command byte with bit 7 set is ignored. `chan_sel` keeps its value and the next 8 bits are again taken as a command.
- R4: Register select codes are: 000 command, 001 mode, 010 filter-high, 011 filter-low, 100 test, 101 conversion data, 110 zero-scale calibration, 111 full-scale calibration. Codes 001 to 100 and a command-register read move 8 bits. Codes 110 and 111 move 24 bits.
- R5: A data-register read moves 16 bits, `conv_data[23:8]`, when bit 6 of filter-high is 0. It moves all 24 bits of `conv_data` when that bit is 1.
- R6: Read data is driven on `sdo` at falling `sclk` edges, MSB first. The first bit appears on the falling edge that follows the command byte's last rising edge. `sdo` changes at no other time.
- R7: A command-register read returns 8 bits: bit 7 is `drdy_n` and bits 6:0 equal bits 6:0 of the reading command byte.
- R8: After one transfer of the selected length, the interface returns to waiting for a command byte.
- R9: After 32 consecutive ones on `sdi` at rising edges, in any phase, the interface returns to the command-wait state with its bit count cleared.
- R10: The calibration registers are held per channel. A value written under one channel is read back only under that channel.
- R11: A write command with register select 000 has no data phase. The next byte is a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idles high |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| drdy_n | input | 1 | Data-ready flag, active low, reported by command reads |
| conv_data | input | 24 | Current conversion result |
| chan_sel | output | 3 | Channel from the last valid command byte |

## Verification
Both serial pins pass through two synchroniser stages and one edge register before the controller reacts. A result therefore appears about three system clocks after the `sclk` edge that causes it. The bench holds each `sclk` level for six system clocks and drives every pin change on a falling system-clock edge. It samples `sdo` five clocks after each falling `sclk` edge, just before the rising edge on which a host would take the bit. It reads `chan_sel` a full half-period after the command byte's last rising edge. Each read is scored by comparing the word collected from `sdo` against an expected word queued before the command was sent.

// File: rtl/cmdif_pkg.sv
package cmdif_pkg;

    localparam int CMD_W = 8;
    localparam int CH_W  = 3;

    typedef enum logic [2:0] {
        RS_CMD  = 3'd0,
        RS_MODE = 3'd1,
        RS_FHI  = 3'd2,
        RS_FLO  = 3'd3,
        RS_TEST = 3'd4,
        RS_DATA = 3'd5,
        RS_ZCAL = 3'd6,
        RS_FCAL = 3'd7
    } regsel_e;

    typedef enum logic {
        ST_CMD  = 1'b0,
        ST_XFER = 1'b1
    } phase_e;

endpackage

// File: rtl/cmdif_sync.sv
module cmdif_sync #(
    parameter int   STAGES    = 2,
    parameter logic SCLK_IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic rise_o,
    output logic fall_o,
    output logic sdi_o
);
    typedef struct packed {
        logic [STAGES-1:0] ck;
        logic [STAGES-1:0] dt;
        logic              prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.ck   = {sy_q.ck[STAGES-2:0], sclk_i};
        sy_d.dt   = {sy_q.dt[STAGES-2:0], sdi_i};
        sy_d.prev = sy_q.ck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q.ck   <= {STAGES{SCLK_IDLE}};
            sy_q.dt   <= '0;
            sy_q.prev <= SCLK_IDLE;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign rise_o = sy_q.ck[STAGES-1] & ~sy_q.prev;
    assign fall_o = ~sy_q.ck[STAGES-1] & sy_q.prev;
    assign sdi_o  = sy_q.dt[STAGES-1];

endmodule

// File: rtl/cmdif_resync.sv
module cmdif_resync #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic sdi_i,
    output logic resync_o
);
    localparam int CW = $clog2(LIMIT);

    logic [CW-1:0] ones_d, ones_q;

    always_comb begin
        ones_d   = ones_q;
        resync_o = 1'b0;
        if (rise_i) begin
            if (!sdi_i) begin
                ones_d = '0;
            end else if (ones_q == CW'(LIMIT - 1)) begin
                resync_o = 1'b1;
                ones_d   = '0;
            end else begin
                ones_d = ones_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ones_q <= '0;
        else        ones_q <= ones_d;
    end

endmodule

// File: rtl/cmdif_regs.sv
module cmdif_regs
    import cmdif_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int SHORT_W = 16,
    parameter int REG_W   = 8,
    parameter int WL_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  regsel_e           wsel,
    input  logic [CH_W-1:0]   wchan,
    input  logic [DATA_W-1:0] wdata,
    input  regsel_e           rsel,
    input  logic [CH_W-1:0]   rchan,
    input  logic [DATA_W-1:0] conv_data,
    output logic [DATA_W-1:0] rdata,
    output logic              wide
);
    localparam int N_CH = 1 << CH_W;

    typedef struct packed {
        logic [REG_W-1:0]             mode;
        logic [REG_W-1:0]             fhi;
        logic [REG_W-1:0]             flo;
        logic [REG_W-1:0]             test;
        logic [N_CH-1:0][DATA_W-1:0]  zcal;
        logic [N_CH-1:0][DATA_W-1:0]  fcal;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (we) begin
            case (wsel)
                RS_MODE: bk_d.mode        = wdata[REG_W-1:0];
                RS_FHI:  bk_d.fhi         = wdata[REG_W-1:0];
                RS_FLO:  bk_d.flo         = wdata[REG_W-1:0];
                RS_TEST: bk_d.test        = wdata[REG_W-1:0];
                RS_ZCAL: bk_d.zcal[wchan] = wdata;
                RS_FCAL: bk_d.fcal[wchan] = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign wide = bk_q.fhi[WL_BIT];

    always_comb begin
        case (rsel)
            RS_MODE: rdata = DATA_W'(bk_q.mode);
            RS_FHI:  rdata = DATA_W'(bk_q.fhi);
            RS_FLO:  rdata = DATA_W'(bk_q.flo);
            RS_TEST: rdata = DATA_W'(bk_q.test);
            RS_DATA: rdata = wide ? conv_data
                                  : DATA_W'(conv_data[DATA_W-1 -: SHORT_W]);
            RS_ZCAL: rdata = bk_q.zcal[rchan];
            RS_FCAL: rdata = bk_q.fcal[rchan];
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/cmdif_top.sv
module cmdif_top
    import cmdif_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int SHORT_W     = 16,
    parameter int REG_W       = 8,
    parameter int ONES_LIMIT  = 32,
    parameter int SYNC_STAGES = 2,
    parameter int WL_BIT      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    input  logic              drdy_n,
    input  logic [DATA_W-1:0] conv_data,
    output logic [CH_W-1:0]   chan_sel
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   len;
        regsel_e            rs;
        logic               rd;
        logic [CH_W-1:0]    chan;
        logic [DATA_W-1:0]  sh;
        logic               sdo;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              sclk_rise, sclk_fall, sdi_s, resync;
    logic              wide, wr_en, accept;
    logic [CMD_W-1:0]  cmd_b;
    regsel_e           dec_rs;
    logic [CNT_W-1:0]  dec_len;
    logic [DATA_W-1:0] reg_rdata, tx_word;
    logic              in_xfer;
    logic [CNT_W-1:0]  xfer_cnt, xfer_len;

    cmdif_sync #(
        .STAGES    (SYNC_STAGES),
        .SCLK_IDLE (1'b1)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk),
        .sdi_i  (sdi),
        .rise_o (sclk_rise),
        .fall_o (sclk_fall),
        .sdi_o  (sdi_s)
    );

    cmdif_resync #(
        .LIMIT (ONES_LIMIT)
    ) u_resync (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (sclk_rise),
        .sdi_i    (sdi_s),
        .resync_o (resync)
    );

    // the byte as it stands on the eighth rising edge
    assign cmd_b  = {ctl_q.sh[CMD_W-2:0], sdi_s};
    assign dec_rs = regsel_e'(cmd_b[6:4]);

    always_comb begin
        case (dec_rs)
            RS_DATA:          dec_len = wide ? CNT_W'(DATA_W) : CNT_W'(SHORT_W);
            RS_ZCAL, RS_FCAL: dec_len = CNT_W'(DATA_W);
            default:          dec_len = CNT_W'(REG_W);
        endcase
    end

    cmdif_regs #(
        .DATA_W  (DATA_W),
        .SHORT_W (SHORT_W),
        .REG_W   (REG_W),
        .WL_BIT  (WL_BIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_en),
        .wsel      (ctl_q.rs),
        .wchan     (ctl_q.chan),
        .wdata     (ctl_d.sh),
        .rsel      (dec_rs),
        .rchan     (cmd_b[CH_W-1:0]),
        .conv_data (conv_data),
        .rdata     (reg_rdata),
        .wide      (wide)
    );

    assign tx_word = (dec_rs == RS_CMD) ? DATA_W'({drdy_n, cmd_b[CMD_W-2:0]})
                                        : reg_rdata;

    always_comb begin
        ctl_d  = ctl_q;
        wr_en  = 1'b0;
        accept = 1'b0;

        if (sclk_rise) begin
            if (ctl_q.phase == ST_CMD) begin
                if (ctl_q.cnt == CNT_W'(CMD_W - 1)) begin
                    ctl_d.cnt = '0;
                    if (!cmd_b[CMD_W-1]) begin
                        accept     = 1'b1;
                        ctl_d.chan = cmd_b[CH_W-1:0];
                        ctl_d.rs   = dec_rs;
                        ctl_d.rd   = cmd_b[3];
                        if (dec_rs != RS_CMD || cmd_b[3]) begin
                            ctl_d.phase = ST_XFER;
                            ctl_d.len   = dec_len;
                            if (cmd_b[3]) begin
                                ctl_d.sh = tx_word << (DATA_W - int'(dec_len));
                            end
                        end
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    ctl_d.sh  = {ctl_q.sh[DATA_W-2:0], sdi_s};
                end
            end else begin
                if (!ctl_q.rd) begin
                    ctl_d.sh = {ctl_q.sh[DATA_W-2:0], sdi_s};
                end
                if (ctl_q.cnt == ctl_q.len - 1'b1) begin
                    ctl_d.phase = ST_CMD;
                    ctl_d.cnt   = '0;
                    wr_en       = !ctl_q.rd;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
        end

        if (sclk_fall) begin
            if (ctl_q.phase == ST_XFER && ctl_q.rd) begin
                ctl_d.sdo = ctl_q.sh[DATA_W-1];
                ctl_d.sh  = {ctl_q.sh[DATA_W-2:0], 1'b0};
            end else begin
                ctl_d.sdo = 1'b0;
            end
        end

        if (resync) begin
            ctl_d.phase = ST_CMD;
            ctl_d.cnt   = '0;
            wr_en       = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.phase <= ST_CMD;
            ctl_q.rs    <= RS_CMD;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sdo      = ctl_q.sdo;
    assign chan_sel = ctl_q.chan;
    assign in_xfer  = (ctl_q.phase == ST_XFER);
    assign xfer_cnt = ctl_q.cnt;
    assign xfer_len = ctl_q.len;

endmodule

// File: rtl/cmdif_checker.sv
module cmdif_checker #(
    parameter int CNT_W = 5,
    parameter int CH_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sclk_fall,
    input logic             sdo,
    input logic             accept,
    input logic [CH_W-1:0]  chan_sel,
    input logic             resync,
    input logic             in_xfer,
    input logic [CNT_W-1:0] xfer_cnt,
    input logic [CNT_W-1:0] xfer_len,
    input logic             wr_en
);

    assert_sdo_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(sdo));

    assert_chan_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(chan_sel));

    assert_resync_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> (!in_xfer && xfer_cnt == '0));

    assert_return_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !in_xfer);

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_xfer |-> (xfer_cnt < xfer_len));

    assert_write_in_xfer_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> in_xfer);

endmodule

bind cmdif_top cmdif_checker #(
    .CNT_W (CNT_W),
    .CH_W  (cmdif_pkg::CH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_fall (sclk_fall),
    .sdo       (sdo),
    .accept    (accept),
    .chan_sel  (chan_sel),
    .resync    (resync),
    .in_xfer   (in_xfer),
    .xfer_cnt  (xfer_cnt),
    .xfer_len  (xfer_len),
    .wr_en     (wr_en)
);

// File: tb/sim_cmdif_top.sv
module sim_cmdif_top;

    localparam int HALF = 24;   // sclk half period in ns, six system clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        sdi = 1'b0;
    logic        sdo;
    logic        drdy_n = 1'b1;
    logic [23:0] conv_data = 24'hABCDEF;
    logic [2:0]  chan_sel;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [23:0] v;
        string       tag;
    } item_t;

    item_t       exp_q[$];
    logic [23:0] got_q[$];

    always #2 clk = ~clk;

    cmdif_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .sdo       (sdo),
        .drdy_n    (drdy_n),
        .conv_data (conv_data),
        .chan_sel  (chan_sel)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [23:0] got, input logic [23:0] expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, expv);
        end
    endtask

    // one serial bit: falling edge with new data, sample sdo, then rising edge
    task automatic bitx(input logic b, output logic o);
        sclk = 1'b0;
        sdi  = b;
        #(HALF - 4);
        o = sdo;
        #4;
        sclk = 1'b1;
        #HALF;
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic o;
        for (int i = 7; i >= 0; i--) bitx(b[i], o);
    endtask

    task automatic wr_reg(input logic [2:0] rs, input logic [2:0] ch,
                          input int len, input logic [23:0] val);
        logic o;
        send_byte({1'b0, rs, 1'b0, ch});
        for (int i = len - 1; i >= 0; i--) bitx(val[i], o);
    endtask

    // driver: queue the expected word, then clock the read
    task automatic rd_reg(input logic [2:0] rs, input logic [2:0] ch,
                          input int len, input logic [23:0] expv, input string tag);
        logic [23:0] acc;
        logic        o;
        item_t       it;
        it.v   = expv;
        it.tag = tag;
        exp_q.push_back(it);
        send_byte({1'b0, rs, 1'b1, ch});
        acc = '0;
        for (int i = 0; i < len; i++) begin
            bitx(1'b0, o);
            acc = {acc[22:0], o};
        end
        got_q.push_back(acc);
    endtask

    // monitor: pair every collected word with its expectation
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() != 0 && exp_q.size() != 0) begin
                item_t       e;
                logic [23:0] g;
                e = exp_q.pop_front();
                g = got_q.pop_front();
                check(g == e.v, e.tag, g, e.v);
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic o;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        check(sdo == 1'b0, "R1 sdo after reset", 24'(sdo), 24'h0);
        check(chan_sel == 3'd0, "R1 chan_sel after reset", 24'(chan_sel), 24'h0);

        // R2, R4: control register writes and reads
        wr_reg(3'b001, 3'd3, 8, 24'h5A);
        check(chan_sel == 3'd3, "R2 channel field taken", 24'(chan_sel), 24'h3);
        rd_reg(3'b001, 3'd3, 8, 24'h5A, "R4 R6 mode readback");
        wr_reg(3'b010, 3'd3, 8, 24'h00);
        wr_reg(3'b011, 3'd3, 8, 24'hC3);
        wr_reg(3'b100, 3'd3, 8, 24'h81);
        rd_reg(3'b011, 3'd1, 8, 24'hC3, "R4 filter-low readback");
        check(chan_sel == 3'd1, "R2 channel from read command", 24'(chan_sel), 24'h1);
        rd_reg(3'b100, 3'd1, 8, 24'h81, "R4 R8 test readback");

        // R5: conversion word length
        rd_reg(3'b101, 3'd0, 16, 24'h00ABCD, "R5 short data word");
        wr_reg(3'b010, 3'd0, 8, 24'h40);
        rd_reg(3'b010, 3'd0, 8, 24'h40, "R4 filter-high readback");
        rd_reg(3'b101, 3'd0, 24, 24'hABCDEF, "R5 long data word");
        conv_data = 24'h13579B;
        rd_reg(3'b101, 3'd2, 24, 24'h13579B, "R5 R8 new data word");

        // R7: command register readback
        drdy_n = 1'b0;
        rd_reg(3'b000, 3'd6, 8, 24'h0E, "R7 status ready");
        drdy_n = 1'b1;
        rd_reg(3'b000, 3'd1, 8, 24'h89, "R7 status not ready");

        // R11: command-register write has no data phase
        send_byte(8'h04);
        check(chan_sel == 3'd4, "R11 channel from command write", 24'(chan_sel), 24'h4);
        rd_reg(3'b001, 3'd4, 8, 24'h5A, "R11 next byte is a command");

        // R3: invalid command ignored
        send_byte(8'hF5);
        check(chan_sel == 3'd4, "R3 invalid byte keeps channel", 24'(chan_sel), 24'h4);
        rd_reg(3'b001, 3'd4, 8, 24'h5A, "R3 framing kept after invalid byte");

        // R10: per-channel calibration
        wr_reg(3'b110, 3'd2, 24, 24'h123456);
        wr_reg(3'b110, 3'd5, 24, 24'h654321);
        wr_reg(3'b111, 3'd2, 24, 24'hFEDCBA);
        rd_reg(3'b110, 3'd2, 24, 24'h123456, "R10 zero-scale ch2");
        rd_reg(3'b110, 3'd5, 24, 24'h654321, "R10 zero-scale ch5");
        rd_reg(3'b111, 3'd2, 24, 24'hFEDCBA, "R10 full-scale ch2");
        rd_reg(3'b111, 3'd5, 24, 24'h000000, "R10 full-scale ch5 untouched");

        // R9: broken framing recovered by a run of ones
        bitx(1'b0, o);
        bitx(1'b1, o);
        bitx(1'b0, o);
        for (int i = 0; i < 32; i++) bitx(1'b1, o);
        rd_reg(3'b001, 3'd0, 8, 24'h5A, "R9 aligned after ones run");
        check(chan_sel == 3'd0, "R9 command decoded after resync", 24'(chan_sel), 24'h0);
        check(sdo == 1'b0, "R6 sdo low in command wait", 24'(sdo), 24'h0);

        repeat (20) @(negedge clk);
        finish_run();
    end

endmodule